// File: doc/BRIEF.md
# Thermal Throttle P-State Sequencer

This block sits between a junction-temperature sensor and the clock and voltage controls of a processor core. Each valid temperature sample (an unsigned 8-bit value in whole degrees Celsius) is compared against a throttle limit and a higher trip limit. When the core is too hot, the block lowers the performance-state index one level at a time. It waits a fixed dwell between levels and stops at the slowest level. It then stays at that level for a minimum time, and for longer while the core is still at or above the limit.

If a throttle episode runs long, the block asks the voltage regulator for a reduced voltage. When the core cools, the block drops that request and then raises the performance index back to nominal, one paced level at a time. A fresh over-limit sample during the climb sends it back down from wherever it stands. A sample at or above the trip limit raises a shutdown output that holds until reset. All intervals are given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `thermal_pstate_seq`

## Requirements
- R1: A sample counts as over the limit only when temp_c is strictly greater than the throttle limit (default 104). A sample equal to the limit is "warm" but not over. Only the most recent sample with temp_valid high is used, and temp_c is ignored while temp_valid is low.
- R2: From nominal (pstate_idx 0), an over-limit sample taken on one rising edge makes pstate_idx become 1 on the next rising edge.
- R3: Each downward step raises pstate_idx by exactly one. Successive downward steps are STEP_US apart, converted to clock cycles.
- R4: pstate_idx never exceeds NUM_PSTATES-1, the slowest level.
- R5: After reaching NUM_PSTATES-1, the block stays there for at least HOLD_US. It stays longer while the latest sample is at or above the limit, and a sample equal to the limit counts.
- R6: vred_req rises once VRED_US has elapsed since throttling began, while the block is still stepping down or holding at the slowest level.
- R7: On leaving the slowest level, vred_req falls on the same edge. The first upward step follows one STEP_US later, and each further step follows one STEP_US after the one before. When pstate_idx reaches 0, throttling falls.
- R8: An over-limit sample during the upward climb makes the block step down one level on the next edge and resume the downward sequence from its current level.
- R9: A sample at or above the trip limit (throttle limit + 20, default 124) sets shutdown on the sampling edge. shutdown stays high until reset, whatever samples follow.
- R10: After reset, pstate_idx is 0 and throttling, vred_req and shutdown are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Strobe marking temp_c as a new sample |
| temp_c | input | 8 | Junction temperature, unsigned whole degrees Celsius |
| pstate_idx | output | $clog2(NUM_PSTATES) | Performance level: 0 is nominal, NUM_PSTATES-1 is the slowest |
| throttling | output | 1 | High while a throttle episode is in progress |
| vred_req | output | 1 | Request for reduced core voltage |
| shutdown | output | 1 | Latched over-temperature trip |

## Verification
A sample is captured on the edge where temp_valid is high. shutdown is visible right after that edge. The first step of pstate_idx is due one edge later. The bench drives at falling edges and checks at falling edges, so it can confirm the step has not yet happened after the capture edge and has happened after the next one. For each later event, the bench counts rising edges from the first step: the STEP, HOLD and VRED intervals are fixed cycle counts. It samples one cycle before and exactly at each due edge. This shows that each change happens neither early nor late.

// File: rtl/thermal_seq_pkg.sv
package thermal_seq_pkg;

    typedef enum logic [1:0] {
        PS_NOMINAL,
        PS_DESCEND,
        PS_FLOOR,
        PS_ASCEND
    } seq_state_e;

    // Convert a microsecond interval into a clock-cycle count, never below one.
    function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                                 input longint unsigned us);
        longint unsigned c;
        c = (clk_hz * us) / 64'd1000000;
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

endpackage

// File: rtl/thermal_temp_sense.sv
module thermal_temp_sense #(
    parameter int unsigned THROTTLE_C = 104,
    parameter int unsigned TRIP_C     = 124
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       temp_valid,
    input  logic [7:0] temp_c,
    output logic       over_o,
    output logic       warm_o,
    output logic       trip_o
);
    localparam logic [7:0] THR_LIM  = 8'(THROTTLE_C);
    localparam logic [7:0] TRIP_LIM = 8'(TRIP_C);

    typedef struct packed {
        logic over;
        logic warm;
        logic trip;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (temp_valid) begin
            s_d.over = (temp_c > THR_LIM);
            s_d.warm = (temp_c >= THR_LIM);
            s_d.trip = s_q.trip | (temp_c >= TRIP_LIM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign over_o = s_q.over;
    assign warm_o = s_q.warm;
    assign trip_o = s_q.trip;

    AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trip |=> s_q.trip); // R9
    AST_OVER_IMPLIES_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.over |-> s_q.warm); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> $stable(s_q.over) && $stable(s_q.warm)); // R1

endmodule

// File: rtl/thermal_step_fsm.sv
module thermal_step_fsm
    import thermal_seq_pkg::*;
#(
    parameter int unsigned NUM_PSTATES = 6,
    parameter int unsigned STEP_CYC    = 500,
    parameter int unsigned HOLD_CYC    = 50000,
    parameter int unsigned VRED_CYC    = 5000000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           over_i,
    input  logic                           warm_i,
    output logic [$clog2(NUM_PSTATES)-1:0] pstate_o,
    output logic                           throttling_o,
    output logic                           vred_o
);
    localparam int unsigned IDX_W   = $clog2(NUM_PSTATES);
    localparam int unsigned TMR_MAX = (STEP_CYC > HOLD_CYC) ? STEP_CYC : HOLD_CYC;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
    localparam int unsigned ESC_W   = $clog2(VRED_CYC + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PSTATES - 1);
    localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(NUM_PSTATES - 2);
    localparam logic [TMR_W-1:0] STEP_LD  = TMR_W'(STEP_CYC - 1);
    localparam logic [TMR_W-1:0] HOLD_LD  = TMR_W'(HOLD_CYC - 1);
    localparam logic [ESC_W-1:0] ESC_MAX  = ESC_W'(VRED_CYC);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [TMR_W-1:0] tmr;
        logic [ESC_W-1:0] esc;
        logic             vred;
    } seq_t;

    seq_t q, n;
    logic go_down;

    always_comb begin
        n       = q;
        go_down = 1'b0;

        if (q.tmr != '0) n.tmr = q.tmr - 1'b1;

        // Episode length counter, saturating at the escalation limit.
        if (q.state != PS_NOMINAL && q.esc != ESC_MAX) n.esc = q.esc + 1'b1;
        if (q.esc == ESC_MAX && (q.state == PS_DESCEND || q.state == PS_FLOOR))
            n.vred = 1'b1;

        case (q.state)
            PS_NOMINAL: begin
                if (over_i) begin
                    go_down = 1'b1;
                    n.esc   = ESC_W'(1);
                end
            end
            PS_DESCEND: begin
                if (q.tmr == '0) go_down = 1'b1;
            end
            PS_FLOOR: begin
                if (q.tmr == '0 && !warm_i) begin
                    n.state = PS_ASCEND;
                    n.tmr   = STEP_LD;
                    n.vred  = 1'b0;
                end
            end
            PS_ASCEND: begin
                if (over_i) begin
                    go_down = 1'b1;
                end else if (q.tmr == '0) begin
                    n.idx = q.idx - 1'b1;
                    if (q.idx == IDX_W'(1)) begin
                        n.state = PS_NOMINAL;
                        n.esc   = '0;
                    end else begin
                        n.tmr = STEP_LD;
                    end
                end
            end
            default: n.state = PS_NOMINAL;
        endcase

        if (go_down) begin
            if (q.idx == LAST_IDX) begin
                n.state = PS_FLOOR;
                n.tmr   = HOLD_LD;
            end else begin
                n.idx = q.idx + 1'b1;
                if (q.idx == PRE_LAST) begin
                    n.state = PS_FLOOR;
                    n.tmr   = HOLD_LD;
                end else begin
                    n.state = PS_DESCEND;
                    n.tmr   = STEP_LD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= PS_NOMINAL;
            q.idx   <= '0;
            q.tmr   <= '0;
            q.esc   <= '0;
            q.vred  <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign pstate_o     = q.idx;
    assign throttling_o = (q.state != PS_NOMINAL);
    assign vred_o       = q.vred;

    AST_ONE_LEVEL_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q.idx == $past(q.idx)) || (q.idx == $past(q.idx) + 1'b1)
                 || (q.idx == $past(q.idx) - 1'b1)); // R3
    AST_FLOOR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= LAST_IDX); // R4
    AST_FAST_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == PS_NOMINAL && over_i) |=> (q.idx == IDX_W'(1))); // R2
    AST_VRED_IN_EPISODE: assert property (@(posedge clk) disable iff (!rst_n)
        q.vred |-> (q.state != PS_NOMINAL) && (q.idx != '0)); // R6
    AST_NOMINAL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == PS_NOMINAL) |-> (q.idx == '0) && !q.vred); // R7
    AST_CLIMB_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == PS_ASCEND && over_i && q.idx != LAST_IDX)
        |=> (q.idx == $past(q.idx) + 1'b1)); // R8

endmodule

// File: rtl/thermal_pstate_seq.sv
module thermal_pstate_seq
    import thermal_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 50000000,
    parameter int unsigned NUM_PSTATES  = 6,
    parameter int unsigned THROTTLE_C   = 104,
    parameter int unsigned TRIP_DELTA_C = 20,
    parameter int unsigned STEP_US      = 10,
    parameter int unsigned HOLD_US      = 1000,
    parameter int unsigned VRED_US      = 100000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           temp_valid,
    input  logic [7:0]                     temp_c,
    output logic [$clog2(NUM_PSTATES)-1:0] pstate_idx,
    output logic                           throttling,
    output logic                           vred_req,
    output logic                           shutdown
);
    localparam int unsigned TRIP_C   = THROTTLE_C + TRIP_DELTA_C;
    localparam int unsigned STEP_CYC = us_to_cycles(CLK_HZ, STEP_US);
    localparam int unsigned HOLD_CYC = us_to_cycles(CLK_HZ, HOLD_US);
    localparam int unsigned VRED_CYC = us_to_cycles(CLK_HZ, VRED_US);

    logic over_s;
    logic warm_s;

    thermal_temp_sense #(
        .THROTTLE_C (THROTTLE_C),
        .TRIP_C     (TRIP_C)
    ) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_valid (temp_valid),
        .temp_c     (temp_c),
        .over_o     (over_s),
        .warm_o     (warm_s),
        .trip_o     (shutdown)
    );

    thermal_step_fsm #(
        .NUM_PSTATES (NUM_PSTATES),
        .STEP_CYC    (STEP_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .VRED_CYC    (VRED_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .over_i       (over_s),
        .warm_i       (warm_s),
        .pstate_o     (pstate_idx),
        .throttling_o (throttling),
        .vred_o       (vred_req)
    );

    AST_SHUTDOWN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> shutdown); // R9
    AST_TRIP_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid && temp_c >= 8'(TRIP_C)) |=> shutdown); // R9

endmodule

// File: tb/thermal_pstate_seq_tb.sv
module thermal_pstate_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       temp_valid = 1'b0;
    logic [7:0] temp_c = 8'd250;
    logic [1:0] pstate_idx;
    logic       throttling;
    logic       vred_req;
    logic       shutdown;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int t0 = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // 1 MHz timebase: step 10 cycles, hold 100 cycles, escalation 300 cycles.
    thermal_pstate_seq #(
        .CLK_HZ      (1000000),
        .NUM_PSTATES (4),
        .THROTTLE_C  (104),
        .TRIP_DELTA_C(20),
        .STEP_US     (10),
        .HOLD_US     (100),
        .VRED_US     (300)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_valid (temp_valid),
        .temp_c     (temp_c),
        .pstate_idx (pstate_idx),
        .throttling (throttling),
        .vred_req   (vred_req),
        .shutdown   (shutdown)
    );

    // {temp[7:0], expect first step, expect shutdown}
    localparam logic [9:0] VEC [8] = '{
        {8'd0,   1'b0, 1'b0},
        {8'd103, 1'b0, 1'b0},
        {8'd104, 1'b0, 1'b0},
        {8'd105, 1'b1, 1'b0},
        {8'd123, 1'b1, 1'b0},
        {8'd124, 1'b1, 1'b1},
        {8'd200, 1'b1, 1'b1},
        {8'd255, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        temp_valid = 1'b0;
        temp_c = 8'd250;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a falling edge; the sample is captured on the next rising edge.
    task automatic apply(input logic [7:0] t);
        temp_valid = 1'b1;
        temp_c = t;
        @(negedge clk);
        temp_valid = 1'b0;
        temp_c = 8'd250;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state; invalid hot data on temp_c must be ignored (R1)
        do_reset();
        chk("R10 pstate", pstate_idx, 0);
        chk("R10 throttling", throttling, 0);
        chk("R10 vred", vred_req, 0);
        chk("R10 shutdown", shutdown, 0);
        repeat (20) @(negedge clk);
        chk("R1 ignored pstate", pstate_idx, 0);
        chk("R1 ignored shutdown", shutdown, 0);

        // Threshold table: R1 compare, R2 latency, R9 trip level
        for (int i = 0; i < 8; i++) begin
            do_reset();
            apply(VEC[i][9:2]);
            chk("R2 no step on capture edge", pstate_idx, 0);
            chk("R9 trip level", shutdown, VEC[i][0]);
            @(negedge clk);
            chk("R1 R2 first step", pstate_idx, VEC[i][1]);
        end

        // Descent, floor, extended hold, escalation, climb
        do_reset();
        apply(8'd110);
        @(negedge clk);
        t0 = cyc;
        chk("R2 step", pstate_idx, 1);
        chk("R7 throttling", throttling, 1);
        wait_to(t0 + 9);
        chk("R3 dwell", pstate_idx, 1);
        wait_to(t0 + 10);
        chk("R3 step2", pstate_idx, 2);
        wait_to(t0 + 19);
        chk("R3 dwell2", pstate_idx, 2);
        wait_to(t0 + 20);
        chk("R3 step3", pstate_idx, 3);
        wait_to(t0 + 60);
        chk("R4 floor", pstate_idx, 3);
        apply(8'd104);
        wait_to(t0 + 150);
        chk("R5 hold while equal", pstate_idx, 3);
        wait_to(t0 + 299);
        chk("R6 vred early", vred_req, 0);
        wait_to(t0 + 300);
        chk("R6 vred", vred_req, 1);
        apply(8'd90);
        wait_to(t0 + 302);
        chk("R7 vred release", vred_req, 0);
        chk("R7 level at release", pstate_idx, 3);
        wait_to(t0 + 311);
        chk("R7 up dwell", pstate_idx, 3);
        wait_to(t0 + 312);
        chk("R7 up1", pstate_idx, 2);
        wait_to(t0 + 322);
        chk("R7 up2", pstate_idx, 1);
        wait_to(t0 + 331);
        chk("R7 up dwell3", pstate_idx, 1);
        wait_to(t0 + 332);
        chk("R7 nominal", pstate_idx, 0);
        chk("R7 throttling low", throttling, 0);

        // Minimum hold, then abort of the climb
        do_reset();
        apply(8'd110);
        apply(8'd90);
        t0 = cyc;
        chk("R2 step", pstate_idx, 1);
        wait_to(t0 + 129);
        chk("R5 min hold", pstate_idx, 3);
        wait_to(t0 + 130);
        chk("R7 first up", pstate_idx, 2);
        chk("R6 no vred short", vred_req, 0);
        apply(8'd110);
        chk("R8 before abort", pstate_idx, 2);
        wait_to(t0 + 132);
        chk("R8 abort step", pstate_idx, 3);
        wait_to(t0 + 200);
        chk("R4 floor after abort", pstate_idx, 3);

        // Latched trip
        do_reset();
        apply(8'd124);
        chk("R9 trip", shutdown, 1);
        apply(8'd30);
        repeat (50) @(negedge clk);
        chk("R9 latched", shutdown, 1);
        do_reset();
        chk("R10 trip cleared", shutdown, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule